// File: doc/BRIEF.md
# Clear-on-read dropped-frame counter register

This block keeps two independent counts of receive frames that were thrown away, and presents both in one 32-bit read-only status word. The first count tracks frames discarded because no host receive buffer was free. The second tracks frames lost to a FIFO overflow, including runt frames shorter than 64 bytes that were rejected. Each count has its own event input that pulses for a single cycle, and each carries a sticky flag that records whether the count has wrapped.

Software reads the word through a simple read strobe with per-byte-lane enables. The read returns the values held before the read. A read clears only the counters whose byte lanes it covers. Nothing can write the register. An event that arrives in the same cycle as a clearing read is kept, so the count becomes one rather than zero.

Top module: `dropcnt_reg`

## Requirements
- R1: After synchronous reset every field is zero, `rd_valid` is low and `rd_data` reads 0.
- R2: Word layout: bits [15:0] hold the buffer-unavailable count, bit 16 is its wrap flag, bits [27:17] hold the FIFO-loss count, and bit 28 is its wrap flag.
- R3: Each cycle with `nobuf_drop_evt` high adds one to the buffer-unavailable count.
- R4: Each cycle with `fifo_loss_evt` high adds one to the FIFO-loss count.
- R5: An increment from all-ones wraps that count to zero and sets its wrap flag. The flag stays set through later increments until the matching clearing read.
- R6: A read with `rd_be[0]` high clears the buffer-unavailable count and its flag.
- R7: A read with `rd_be[2]` high clears the FIFO-loss count and its flag.
- R8: An event in the same cycle as a clearing read of its counter leaves that count at 1 with its flag clear.
- R9: A read with neither `rd_be[0]` nor `rd_be[2]` set changes no state.
- R10: Bits [31:29] of `rd_data` always read zero.
- R11: `rd_data` is registered. It is updated one cycle after `rd_en` with the values held before any clear, `rd_valid` is high for exactly that cycle, and `rd_data` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_be | input | 4 | Byte-lane enables of the read |
| nobuf_drop_evt | input | 1 | Pulse: frame dropped because no host buffer was free |
| fifo_loss_evt | input | 1 | Pulse: frame lost to FIFO overflow or runt rejection |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle when `rd_data` carries a new read result |

## Verification
The bench builds the block with its default widths of 16 and 11 bits. These keep the real field positions, and both wrap points can be reached by plain pulse counting: 65,536 pulses for the wide counter and 2,048 for the narrow one, well within the run budget. Both wraps are driven in one long burst. Clearing reads are then issued with and without a coincident event, and non-clearing reads with the other lanes set.

// File: rtl/dropcnt_pkg.sv
package dropcnt_pkg;
  // Default field widths and the byte lanes whose read enable clears each counter
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_NOBUF_W  = 16;
  localparam int DEF_LOSS_W   = 11;
  localparam int DEF_NOBUF_LN = 0;
  localparam int DEF_LOSS_LN  = 2;
endpackage

// File: rtl/dropcnt_lane_sel.sv
module dropcnt_lane_sel #(
  parameter int BE_W = 4,
  parameter int LANE = 0
) (
  input  logic            rd_en,
  input  logic [BE_W-1:0] rd_be,
  output logic            clr
);
  always_comb clr = rd_en & rd_be[LANE];
endmodule

// File: rtl/dropcnt_field.sv
module dropcnt_field #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         wrapped
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      cnt     <= evt ? {{(W-1){1'b0}}, 1'b1} : '0;
      wrapped <= 1'b0;
    end else if (evt) begin
      cnt <= cnt + 1'b1;
      if (cnt == MAXV) wrapped <= 1'b1;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr && !evt |=> cnt == '0 && !wrapped); // R6 R7
  AST_CLEAR_KEEP_EVT: assert property (@(posedge clk) disable iff (rst)
    clr && evt |=> cnt == {{(W-1){1'b0}}, 1'b1} && !wrapped); // R8
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    !clr && evt && cnt != MAXV |=> cnt == $past(cnt) + 1'b1); // R3 R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    !clr && evt && cnt == MAXV |=> cnt == '0 && wrapped); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    wrapped && !clr |=> wrapped); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clr && !evt |=> $stable(cnt) && $stable(wrapped)); // R9
endmodule

// File: rtl/dropcnt_pack.sv
module dropcnt_pack #(
  parameter int DATA_W  = 32,
  parameter int NOBUF_W = 16,
  parameter int LOSS_W  = 11
) (
  input  logic [NOBUF_W-1:0] nobuf_cnt,
  input  logic               nobuf_wrap,
  input  logic [LOSS_W-1:0]  loss_cnt,
  input  logic               loss_wrap,
  output logic [DATA_W-1:0]  word
);
  localparam int LOSS_LSB  = NOBUF_W + 1;
  localparam int LOSS_FLAG = NOBUF_W + 1 + LOSS_W;

  always_comb begin
    word                      = '0;
    word[NOBUF_W-1:0]         = nobuf_cnt;
    word[NOBUF_W]             = nobuf_wrap;
    word[LOSS_LSB +: LOSS_W]  = loss_cnt;
    word[LOSS_FLAG]           = loss_wrap;
  end
endmodule

// File: rtl/dropcnt_reg.sv
module dropcnt_reg #(
  parameter int DATA_W   = dropcnt_pkg::DEF_DATA_W,
  parameter int NOBUF_W  = dropcnt_pkg::DEF_NOBUF_W,
  parameter int LOSS_W   = dropcnt_pkg::DEF_LOSS_W,
  parameter int NOBUF_LN = dropcnt_pkg::DEF_NOBUF_LN,
  parameter int LOSS_LN  = dropcnt_pkg::DEF_LOSS_LN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [3:0]        rd_be,
  input  logic              nobuf_drop_evt,
  input  logic              fifo_loss_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int BE_W   = 4;
  localparam int USED_W = NOBUF_W + LOSS_W + 2;
  localparam int RSV_W  = DATA_W - USED_W;

  logic               nobuf_clr, loss_clr;
  logic [NOBUF_W-1:0] nobuf_cnt;
  logic [LOSS_W-1:0]  loss_cnt;
  logic               nobuf_wrap, loss_wrap;
  logic [DATA_W-1:0]  packed_w;

  dropcnt_lane_sel #(.BE_W(BE_W), .LANE(NOBUF_LN)) u_nobuf_sel (
    .rd_en(rd_en), .rd_be(rd_be), .clr(nobuf_clr));
  dropcnt_lane_sel #(.BE_W(BE_W), .LANE(LOSS_LN)) u_loss_sel (
    .rd_en(rd_en), .rd_be(rd_be), .clr(loss_clr));

  dropcnt_field #(.W(NOBUF_W)) u_nobuf_cnt (
    .clk(clk), .rst(rst), .evt(nobuf_drop_evt), .clr(nobuf_clr),
    .cnt(nobuf_cnt), .wrapped(nobuf_wrap));
  dropcnt_field #(.W(LOSS_W)) u_loss_cnt (
    .clk(clk), .rst(rst), .evt(fifo_loss_evt), .clr(loss_clr),
    .cnt(loss_cnt), .wrapped(loss_wrap));

  dropcnt_pack #(.DATA_W(DATA_W), .NOBUF_W(NOBUF_W), .LOSS_W(LOSS_W)) u_pack (
    .nobuf_cnt(nobuf_cnt), .nobuf_wrap(nobuf_wrap),
    .loss_cnt(loss_cnt), .loss_wrap(loss_wrap), .word(packed_w));

  // Snapshot register: captures pre-clear values on each read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= packed_w;
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1 -: RSV_W] == '0); // R10
  AST_READ_SNAP: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid && rd_data == $past(packed_w)); // R11
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid && $stable(rd_data)); // R11
  AST_OTHER_LANES: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_be[NOBUF_LN] && !rd_be[LOSS_LN] && !nobuf_drop_evt && !fifo_loss_evt
    |=> $stable(packed_w)); // R9
endmodule

// File: tb/dropcnt_reg_tb.sv
module dropcnt_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_be = 4'b0;
  logic        nobuf_drop_evt = 1'b0;
  logic        fifo_loss_evt = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  always #2.5 clk = ~clk; // 200 MHz

  dropcnt_reg u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_be(rd_be),
    .nobuf_drop_evt(nobuf_drop_evt), .fifo_loss_evt(fifo_loss_evt),
    .rd_data(rd_data), .rd_valid(rd_valid));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_rd = 32'h0;

  // Reference model from the requirements
  int m_nb = 0, m_ls = 0;
  bit m_nbf = 0, m_lsf = 0;

  function automatic logic [31:0] pack_model();
    logic [31:0] w;
    w = 32'h0;
    w[15:0]  = m_nb[15:0];   // R2
    w[16]    = m_nbf;
    w[27:17] = m_ls[10:0];
    w[28]    = m_lsf;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; pushes expected read data to the scoreboard
  task automatic step(input bit nb, input bit ls, input bit rd, input logic [3:0] be,
                      input string tag);
    @(negedge clk);
    nobuf_drop_evt = nb;
    fifo_loss_evt  = ls;
    rd_en          = rd;
    rd_be          = be;
    if (rd) begin
      exp_q.push_back(pack_model());
      tag_q.push_back(tag);
    end
    if (rd && be[0]) begin                       // R6 R8
      m_nb = nb ? 1 : 0; m_nbf = 0;
    end else if (nb) begin                       // R3 R5
      if (m_nb == 65535) begin m_nb = 0; m_nbf = 1; end else m_nb++;
    end
    if (rd && be[2]) begin                       // R7 R8
      m_ls = ls ? 1 : 0; m_lsf = 0;
    end else if (ls) begin                       // R4 R5
      if (m_ls == 2047) begin m_ls = 0; m_lsf = 1; end else m_ls++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 4'b0, "");
  endtask

  // Monitor: compares each read result against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected rd_valid actual=1 expected=0");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
        check("R10 reserved bits", {29'h0, rd_data[31:29]}, 32'h0);
        last_rd = rd_data;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 rd_valid in reset", {31'h0, rd_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
    step(0, 0, 1, 4'b1111, "R1 first read zero");
    idle(2);

    // R3 R4: counting, R2 layout
    for (int i = 0; i < 5; i++) step(1, i < 3, 0, 4'b0, "");
    step(0, 0, 1, 4'b0000, "R3 R4 R2 counts 5 and 3");
    idle(2);
    check("R11 rd_data held", rd_data, last_rd);
    check("R11 rd_valid low when idle", {31'h0, rd_valid}, 32'h0);

    // R9: reads on lanes 1 and 3 only
    step(0, 0, 1, 4'b1010, "R9 non-clearing read");
    step(0, 0, 1, 4'b1010, "R9 repeat read unchanged");
    idle(1);

    // R6: lane 0 clears only the buffer-unavailable counter
    step(0, 0, 1, 4'b0001, "R6 pre-clear value");
    step(0, 0, 1, 4'b0000, "R6 counter cleared");
    // R7 R8: lane 2 clear with coincident event
    step(0, 1, 1, 4'b0100, "R7 pre-clear value");
    step(0, 0, 1, 4'b0000, "R8 loss count is 1 after clear+event");
    idle(2);

    // R5: wrap both counters in one burst
    for (int i = 0; i < 65537; i++) step(1, i < 2049, 0, 4'b0, "");
    step(0, 0, 1, 4'b0000, "R5 both wrapped, flags set");
    step(1, 1, 0, 4'b0, "");
    step(1, 0, 0, 4'b0, "");
    step(0, 0, 1, 4'b1010, "R5 flags sticky after more counts");
    step(1, 0, 1, 4'b0001, "R6 pre-clear with flag");
    step(0, 0, 1, 4'b0000, "R8 nobuf count 1 flag clear");
    step(0, 0, 1, 4'b0100, "R7 pre-clear loss flag");
    step(0, 0, 1, 4'b0000, "R7 loss cleared with flag");
    idle(3);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule